// File: doc/BRIEF.md
# Daisy-Chain Multi-Channel Frame Receiver

This block sits on the host side of a chain of serially linked converters. Every converter in the chain shifts its result out through the serial output of the first device. The host therefore sees three lines: a serial clock, a serial data line and an active-low frame strobe. Only the first device drives the frame strobe, so it marks the start of each set of simultaneous samples. The strobe is low while the first device's word is shifted out. It is high again while the words of the other devices follow on the same data line.

The receiver brings the three lines into the system clock domain through a synchronizer and detects their edges there. A falling edge of the strobe opens a set. The receiver then takes one bit on each rising edge of the serial clock until it holds one 32-bit word per channel. When the last bit is in, it publishes the words per channel, each also split into a 24-bit conversion field and an 8-bit status field, and raises a single-cycle valid pulse. If a new set starts before the current one is complete, the partial set is discarded and an overrun pulse is raised.

Top module: `chain_frame_rx`

## Requirements
- R1: While reset is held, `set_valid` and `overrun` are 0 and every bit of `ch_words`, `ch_data` and `ch_status` is 0.
- R2: A falling edge of `fsync_n_in` opens a set. `sdata_in` is sampled on each rising edge of `sclk_in`, and each word is assembled most significant bit first. All three inputs pass through a synchronizer, so each level must be held for at least three system clock cycles.
- R3: The words are stored in the order they arrive. The first word of a set, from the device nearest the host, appears on `ch_words[31:0]`, and word k appears on `ch_words[32*k+31:32*k]`.
- R4: Once `fsync_n_in` has risen after the first word, bit counting continues until all NUM_CH×32 bits of the set have been taken.
- R5: Each complete set produces exactly one `set_valid` pulse, one system clock cycle wide. It follows the rising serial clock edge of the last bit.
- R6: `ch_words`, `ch_data` and `ch_status` stay unchanged between two complete sets.
- R7: For channel k, `ch_data[24*k+23:24*k]` is bits 31..8 of that channel's word, and `ch_status[8*k+7:8*k]` is bits 7..0 of it.
- R8: A falling edge of `fsync_n_in` while a set is still open drops the partial set without a valid pulse and without changing the outputs. It raises `overrun` for one cycle and restarts the bit count from zero.
- R9: Rising serial clock edges that arrive while no set is open are ignored. They do not change the outputs, raise no pulse, and do not disturb the next set.
- R10: When a frame-strobe falling edge and a serial clock rising edge are detected in the same system cycle, the bit is taken as the first bit of the new set.
- R11: The chain length is the parameter NUM_CH. A receiver built for a shorter chain completes its set after NUM_CH words and ignores any words that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the chain |
| fsync_n_in | input | 1 | Active-low frame strobe from the first device |
| sdata_in | input | 1 | Serial data from the first device |
| set_valid | output | 1 | One-cycle pulse when a full set is stored |
| overrun | output | 1 | One-cycle pulse when a partial set is dropped |
| ch_words | output | NUM_CH*32 | Raw 32-bit word for each channel, channel 0 in the low bits |
| ch_data | output | NUM_CH*24 | Conversion field for each channel |
| ch_status | output | NUM_CH*8 | Status field for each channel |

## Verification
Two functions can land in the same system cycle: the start of a set, which is also the overrun restart, and the capture of a bit. The bench drives the strobe low and the serial clock high at the same clock edge. Because both lines go through synchronizers of equal depth, the two edges are seen together. The check is that the stored set matches the transmitted words exactly, which can only happen if that coinciding bit became bit 31 of channel 0. No overrun must be counted for it. A second case starts a new set in the middle of the second word, and the bench checks that the old words survive and that exactly one overrun is counted.

// File: rtl/chain_rx_pkg.sv
package chain_rx_pkg;
    typedef enum logic {
        RX_IDLE    = 1'b0,
        RX_COLLECT = 1'b1
    } rx_state_e;

    localparam int unsigned CHAIN_WORD_BITS = 32;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    parameter logic [WIDTH-1:0] FALL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] strobe_i,
    input  logic             side_i,
    output logic [WIDTH-1:0] edge_o,
    output logic             side_o
);
    typedef struct packed {
        logic [STAGES:0][WIDTH-1:0] pipe;
        logic [STAGES-1:0]          side;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe = {s_q.pipe[STAGES-1:0], strobe_i};
        if (STAGES > 1) begin
            s_d.side = {s_q.side[STAGES-2:0], side_i};
        end else begin
            s_d.side[0] = side_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe <= {(STAGES+1){RESET_VAL}};
            s_q.side <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
        if (FALL_MASK[i]) begin : g_fall
            assign edge_o[i] = s_q.pipe[STAGES][i] & ~s_q.pipe[STAGES-1][i];
        end else begin : g_rise
            assign edge_o[i] = ~s_q.pipe[STAGES][i] & s_q.pipe[STAGES-1][i];
        end
    end

    assign side_o = s_q.side[STAGES-1];
endmodule

// File: rtl/bit_collector.sv
module bit_collector
    import chain_rx_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned WORD_W = CHAIN_WORD_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     bit_stb_i,
    input  logic                     bit_val_i,
    output logic                     set_valid_o,
    output logic                     overrun_o,
    output logic [NUM_CH*WORD_W-1:0] set_bits_o
);
    localparam int unsigned TOT   = NUM_CH * WORD_W;
    localparam int unsigned CNT_W = $clog2(TOT + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOT - 1);

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [TOT-1:0]     shf;
        logic [TOT-1:0]     held;
        logic               vld;
        logic               ovr;
    } col_t;

    col_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        c_d.ovr = 1'b0;
        if (start_i) begin
            c_d.ovr = (c_q.st == RX_COLLECT);
            c_d.st  = RX_COLLECT;
            c_d.cnt = '0;
            if (bit_stb_i) begin
                c_d.shf = {c_q.shf[TOT-2:0], bit_val_i};
                c_d.cnt = CNT_W'(1);
            end
        end else if (c_q.st == RX_COLLECT && bit_stb_i) begin
            c_d.shf = {c_q.shf[TOT-2:0], bit_val_i};
            if (c_q.cnt == LAST_IDX) begin
                c_d.st   = RX_IDLE;
                c_d.cnt  = '0;
                c_d.held = c_d.shf;
                c_d.vld  = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= RX_IDLE;
            c_q.cnt  <= '0;
            c_q.shf  <= '0;
            c_q.held <= '0;
            c_q.vld  <= 1'b0;
            c_q.ovr  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign set_valid_o = c_q.vld;
    assign overrun_o   = c_q.ovr;
    assign set_bits_o  = c_q.held;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.vld |=> !c_q.vld); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.vld |-> $stable(c_q.held)); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt < CNT_W'(TOT)); // R4
    AST_OVR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.ovr |-> (c_q.st == RX_COLLECT && c_q.cnt <= CNT_W'(1))); // R8
    AST_NO_VALID_WITH_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_q.vld && c_q.ovr)); // R8
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == RX_IDLE) |-> (c_q.cnt == '0)); // R9
endmodule

// File: rtl/word_splitter.sv
module word_splitter #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DATA_W = 24
) (
    input  logic [NUM_CH*WORD_W-1:0]          set_bits_i,
    output logic [NUM_CH*WORD_W-1:0]          words_o,
    output logic [NUM_CH*DATA_W-1:0]          data_o,
    output logic [NUM_CH*(WORD_W-DATA_W)-1:0] status_o
);
    localparam int unsigned STAT_W = WORD_W - DATA_W;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [WORD_W-1:0] word_k;
        assign word_k = set_bits_i[(NUM_CH-1-k)*WORD_W +: WORD_W];
        assign words_o[k*WORD_W +: WORD_W]  = word_k;
        assign data_o[k*DATA_W +: DATA_W]   = word_k[WORD_W-1 -: DATA_W];
        assign status_o[k*STAT_W +: STAT_W] = word_k[STAT_W-1:0];
    end
endmodule

// File: rtl/chain_frame_rx.sv
module chain_frame_rx
    import chain_rx_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned WORD_W      = CHAIN_WORD_BITS,
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sclk_in,
    input  logic                                fsync_n_in,
    input  logic                                sdata_in,
    output logic                                set_valid,
    output logic                                overrun,
    output logic [NUM_CH*WORD_W-1:0]            ch_words,
    output logic [NUM_CH*DATA_W-1:0]            ch_data,
    output logic [NUM_CH*(WORD_W-DATA_W)-1:0]   ch_status
);
    localparam int unsigned TOT = NUM_CH * WORD_W;

    logic [1:0]     edges;
    logic           bit_val;
    logic [TOT-1:0] set_bits;

    edge_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (2),
        .RESET_VAL(2'b10),
        .FALL_MASK(2'b10)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_i({fsync_n_in, sclk_in}),
        .side_i  (sdata_in),
        .edge_o  (edges),
        .side_o  (bit_val)
    );

    bit_collector #(
        .NUM_CH(NUM_CH),
        .WORD_W(WORD_W)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (edges[1]),
        .bit_stb_i  (edges[0]),
        .bit_val_i  (bit_val),
        .set_valid_o(set_valid),
        .overrun_o  (overrun),
        .set_bits_o (set_bits)
    );

    word_splitter #(
        .NUM_CH(NUM_CH),
        .WORD_W(WORD_W),
        .DATA_W(DATA_W)
    ) u_split (
        .set_bits_i(set_bits),
        .words_o   (ch_words),
        .data_o    (ch_data),
        .status_o  (ch_status)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!set_valid && !overrun)); // R1
endmodule

// File: tb/tb_chain_frame_rx.sv
module tb_chain_frame_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic fsn = 1'b1;
    logic sd = 1'b0;
    always #5 clk = ~clk;

    logic         v4, o4, v3, o3;
    logic [127:0] w4;
    logic [95:0]  d4;
    logic [31:0]  s4;
    logic [95:0]  w3;
    logic [71:0]  d3;
    logic [23:0]  s3;

    chain_frame_rx dut (.clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fsync_n_in(fsn),
        .sdata_in(sd), .set_valid(v4), .overrun(o4), .ch_words(w4), .ch_data(d4), .ch_status(s4));
    chain_frame_rx #(.NUM_CH(3)) dut3 (.clk(clk), .rst_n(rst_n), .sclk_in(sclk), .fsync_n_in(fsn),
        .sdata_in(sd), .set_valid(v3), .overrun(o3), .ch_words(w3), .ch_data(d3), .ch_status(s3));

    int errors = 0, checks = 0;
    int vc4 = 0, vc3 = 0, oc4 = 0, oc3 = 0;
    bit done = 1'b0;

    always @(posedge clk) if (rst_n) begin
        if (v4) vc4++;
        if (v3) vc3++;
        if (o4) oc4++;
        if (o3) oc3++;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int s, int c);
        case (s)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h1 << (c * 8 + 3);
            default: return 32'h9E37_79B9 * 32'(s * 4 + c + 1) + 32'(s);
        endcase
    endfunction

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sclk = 1'b0; sd = b; hold(3);
        sclk = 1'b1; hold(3);
    endtask

    task automatic send_set(int s, int nbits, bit coincide);
        int sent = 0;
        for (int w = 0; w < 4; w++) begin
            for (int b = 31; b >= 0; b--) begin
                logic bv;
                if (sent == nbits) return;
                bv = exp_word(s, w)[b];
                if (w == 0 && b == 31) begin
                    sclk = 1'b0; sd = bv; hold(3);
                    fsn = 1'b0;
                    if (!coincide) hold(3);
                    sclk = 1'b1; hold(3);
                end else begin
                    send_bit(bv);
                end
                sent++;
                if (w == 0 && b == 0) fsn = 1'b1;
            end
        end
    endtask

    task automatic check_set(int s, string tag);
        for (int c = 0; c < 4; c++) begin
            check({tag, " R3 word"}, 64'(w4[c*32 +: 32]), 64'(exp_word(s, c)));
            check("R7 data", 64'(d4[c*24 +: 24]), 64'(exp_word(s, c) >> 8));
            check("R7 status", 64'(s4[c*8 +: 8]), 64'(exp_word(s, c) & 32'hFF));
        end
        check("R4 last word after strobe high", 64'(w4[96 +: 32]), 64'(exp_word(s, 3)));
        for (int c = 0; c < 3; c++)
            check("R11 short chain word", 64'(w3[c*32 +: 32]), 64'(exp_word(s, c)));
        check("R11 short chain data", 64'(d3[0 +: 24]), 64'(exp_word(s, 0) >> 8));
        check("R11 short chain status", 64'(s3[16 +: 8]), 64'(exp_word(s, 2) & 32'hFF));
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pv4, pv3, po4, po3;
        hold(5);
        // R1 reset state
        check("R1 valid", 64'(v4), 64'd0);
        check("R1 overrun", 64'(o4), 64'd0);
        check("R1 words", 64'(|w4 | |d4 | |s4 | |w3), 64'd0);
        rst_n = 1'b1;
        hold(5);

        // R2 R3 R5: sweep of patterns
        for (int s = 0; s < 6; s++) begin
            pv4 = vc4; pv3 = vc3;
            send_set(s, 128, 1'b0);
            hold(10);
            check("R5 one pulse per set", 64'(vc4 - pv4), 64'd1);
            check("R11 short chain one pulse", 64'(vc3 - pv3), 64'd1);
            check_set(s, "R2");
        end

        // R9 R6: stray serial clocks with no open set
        pv4 = vc4; po4 = oc4;
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        hold(10);
        check("R9 no pulse from stray clocks", 64'(vc4 - pv4), 64'd0);
        check("R9 no overrun from stray clocks", 64'(oc4 - po4), 64'd0);
        check("R6 words held", 64'(w4[0 +: 32]), 64'(exp_word(5, 0)));
        check("R6 words held ch3", 64'(w4[96 +: 32]), 64'(exp_word(5, 3)));
        pv4 = vc4;
        send_set(6, 128, 1'b0);
        hold(10);
        check("R9 next set after strays", 64'(vc4 - pv4), 64'd1);
        check_set(6, "R9");

        // R8: new set starts in the middle of the second word
        pv4 = vc4; pv3 = vc3; po4 = oc4; po3 = oc3;
        send_set(7, 40, 1'b0);
        hold(10);
        check("R8 no pulse for partial", 64'(vc4 - pv4), 64'd0);
        check("R8 old words kept", 64'(w4[32 +: 32]), 64'(exp_word(6, 1)));
        send_set(8, 128, 1'b0);
        hold(10);
        check("R8 one overrun", 64'(oc4 - po4), 64'd1);
        check("R8 one overrun short chain", 64'(oc3 - po3), 64'd1);
        check("R8 restarted set completes", 64'(vc4 - pv4), 64'd1);
        check_set(8, "R8");

        // R10: strobe fall and first clock rise seen in the same cycle
        pv4 = vc4; po4 = oc4;
        send_set(9, 128, 1'b1);
        hold(10);
        check("R10 set completes", 64'(vc4 - pv4), 64'd1);
        check("R10 no overrun", 64'(oc4 - po4), 64'd0);
        check_set(9, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule